// File: doc/BRIEF.md
# Array Sleep-Entry and Wake Sequencer

This block decides when one SRAM bank may drop its virtual ground rail into low-voltage retention and when it must pull the rail back to true ground. It watches the access channel into the bank. In the idle mode, it counts the cycles that pass with no accepted access, and it puts the bank to sleep once that count reaches a programmed threshold. In the decay mode, a free-running timer with a programmable period issues the sleep request instead. A short period stands for a high-leakage corner. An accepted access restarts the decay timer.

Two outputs drive the rail-restore devices. `early_wake` turns on first, to begin discharging the rail gently. `full_wake` follows a fixed number of cycles later and ties the rail hard to ground. The access channel is valid/ready. A requester raises `acc_valid` and holds it, with its address and data stable elsewhere, until it sees `acc_ready` high at a clock edge. Ready is low while the bank sleeps or is waking. Raising valid while the bank sleeps is what starts the wake sequence. Ready never rises in the same cycle that full wake first appears.

Top module: `array_sleep_ctrl`

## Requirements
- R1: During and after reset the state is ACTIVE, `early_wake`, `full_wake` and `acc_ready` are 1, and the latched idle threshold is 0, so idle mode keeps the bank awake until the first counter restart.
- R2: With `decay_en` low and a latched threshold L > 0, the state becomes SLEEP at the clock edge that ends the L-th consecutive cycle without an accepted access since the last restart.
- R3: An accepted access (`acc_valid` and `acc_ready` both high at an edge) restarts the idle count, and the threshold is sampled from `idle_limit` only at a restart (an accepted access or the end of a wake). A change between restarts has no effect, and the state is never SLEEP in the cycle after an accepted access.
- R4: A latched threshold of 0 keeps the bank ACTIVE indefinitely while `decay_en` is low.
- R5: In SLEEP, `early_wake`, `full_wake` and `acc_ready` are all 0.
- R6: `acc_valid` seen in SLEEP moves the state to WAKING at the next edge. In WAKING, `early_wake` is 1 and `full_wake` is 0 for WAKE_GAP cycles. Then `full_wake` is 1 with `acc_ready` still 0 for one cycle, and after that the state is ACTIVE with `acc_ready` 1.
- R7: `acc_ready` is 1 exactly in ACTIVE. In SLEEP, the state holds while `acc_valid` is low.
- R8: With `decay_en` high, a decay counter advances every cycle in every state. It ticks in the cycle in which it has counted `decay_period` cycles since its last restart or tick. `decay_period` is read live, and 0 never ticks. A tick in ACTIVE without an accepted access moves the state to SLEEP. The idle threshold is ignored in this mode.
- R9: The decay counter restarts on an accepted access and at the end of a wake.
- R10: `state_o` encodes ACTIVE as 0, WAKING as 1 and SLEEP as 2. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request, held until accepted |
| acc_ready | output | 1 | Bank awake and accepting the access |
| idle_limit | input | CNT_W | Idle-cycle threshold, latched at each restart (0 = never sleep) |
| decay_en | input | 1 | Selects the periodic decay mode |
| decay_period | input | CNT_W | Decay tick period in cycles (0 = no tick) |
| early_wake | output | 1 | First-stage rail restore enable |
| full_wake | output | 1 | Full-strength rail restore enable |
| state_o | output | 2 | Sequencer state (0 ACTIVE, 1 WAKING, 2 SLEEP) |

## Verification
A corrupted sequencer state appears at the ports in the same cycle, because the wake outputs and ready are decoded straight from it. Such a fault shows as ready high while the rail floats, or as both wake stages rising together. A wrong idle or decay count stays hidden until the next expiry. There it shows as sleep entry one or more cycles early or late, or as sleep that never comes. For that reason the bench checks every cycle against a model and places exact expiries on chosen edges. A wrong wake-spacing count shows in the first wake, as a changed gap between the two stages or as ready arriving before full wake.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_WAKING = 2'd1,
    ST_SLEEP  = 2'd2
  } slp_state_e;
endpackage

// File: rtl/slp_idle_count.sv
module slp_idle_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [CNT_W-1:0] limit_in,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // expiry fires on the cycle that completes the lim_q-th idle cycle
  assign expire  = (lim_q != '0) && (cnt_inc >= {1'b0, lim_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      lim_q <= limit_in;
    end else if (advance && (cnt_q != '1)) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/slp_decay_timer.sv
module slp_decay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] dcnt_q;
  logic [CNT_W:0]   dcnt_inc;

  assign dcnt_inc = {1'b0, dcnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign tick     = enable && (period != '0) && (dcnt_inc >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt_q <= '0;
    end else if (restart || tick) begin
      dcnt_q <= '0;
    end else begin
      dcnt_q <= dcnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/slp_wake_stage.sv
module slp_wake_stage #(
  parameter int WAKE_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic full,
  output logic last
);
  localparam int GW = (WAKE_GAP < 2) ? 1 : $clog2(WAKE_GAP + 1);
  localparam logic [GW-1:0] GAP_V = GW'(WAKE_GAP);

  logic [GW-1:0] left_q;

  // down-counter preloaded while idle; reaching zero marks the full stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= GAP_V;
    end else if (!busy) begin
      left_q <= GAP_V;
    end else if (left_q != '0) begin
      left_q <= left_q - GW'(1);
    end
  end

  assign full = busy && (left_q == '0);
  assign last = full;
endmodule

// File: rtl/array_sleep_ctrl.sv
module array_sleep_ctrl
  import slp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WAKE_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [CNT_W-1:0] idle_limit,
  input  logic             decay_en,
  input  logic [CNT_W-1:0] decay_period,
  output logic             early_wake,
  output logic             full_wake,
  output logic [1:0]       state_o
);
  slp_state_e state_q, state_d;
  logic       is_active, is_waking, is_sleep;
  logic       accept, wake_done, restart;
  logic       idle_expire, decay_tick, sleep_req;
  logic       stage_full;

  assign is_active = (state_q == ST_ACTIVE);
  assign is_waking = (state_q == ST_WAKING);
  assign is_sleep  = (state_q == ST_SLEEP);
  assign accept    = acc_valid && is_active;
  assign restart   = accept || wake_done;

  slp_idle_count #(.CNT_W(CNT_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .advance  (is_active && !accept),
    .limit_in (idle_limit),
    .expire   (idle_expire)
  );

  slp_decay_timer #(.CNT_W(CNT_W)) u_decay (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (decay_en),
    .restart (restart),
    .period  (decay_period),
    .tick    (decay_tick)
  );

  slp_wake_stage #(.WAKE_GAP(WAKE_GAP)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (is_waking),
    .full  (stage_full),
    .last  (wake_done)
  );

  assign sleep_req = decay_en ? decay_tick : idle_expire;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: if (!accept && sleep_req) state_d = ST_SLEEP;
      ST_WAKING: if (wake_done)            state_d = ST_ACTIVE;
      ST_SLEEP:  if (acc_valid)            state_d = ST_WAKING;
      default:                             state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_ACTIVE;
    else        state_q <= state_d;
  end

  assign acc_ready  = is_active;
  assign early_wake = !is_sleep;
  assign full_wake  = is_active || stage_full;
  assign state_o    = state_q;
endmodule

// File: rtl/slp_checker.sv
module slp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_ready,
  input logic       early_wake,
  input logic       full_wake,
  input logic [1:0] state_o
);
  assert_rails_off_in_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |-> (!full_wake && !early_wake && !acc_ready));

  assert_ready_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> full_wake);

  assert_full_needs_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_wake |-> early_wake);

  assert_staged_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_wake) |-> !full_wake);

  assert_ready_after_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_ready) |-> $past(full_wake));

  assert_sleep_to_waking_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && acc_valid) |=> (state_o == 2'd1));

  assert_sleep_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !acc_valid) |=> (state_o == 2'd2));

  assert_no_sleep_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> (state_o != 2'd2));

  assert_legal_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);
endmodule

bind array_sleep_ctrl slp_checker u_slp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .early_wake (early_wake),
  .full_wake  (full_wake),
  .state_o    (state_o)
);

// File: tb/tb_array_sleep_ctrl.sv
module tb_array_sleep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int GAP        = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acc_valid;
  logic             acc_ready;
  logic [CNT_W-1:0] idle_limit;
  logic             decay_en;
  logic [CNT_W-1:0] decay_period;
  logic             early_wake;
  logic             full_wake;
  logic [1:0]       state_o;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  // reference model state
  int m_st, m_cnt, m_lim, m_dcnt, m_wcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  array_sleep_ctrl #(.CNT_W(CNT_W), .WAKE_GAP(GAP)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_ready    (acc_ready),
    .idle_limit   (idle_limit),
    .decay_en     (decay_en),
    .decay_period (decay_period),
    .early_wake   (early_wake),
    .full_wake    (full_wake),
    .state_o      (state_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_full();
    return (m_st == 0 || (m_st == 1 && m_wcnt == GAP)) ? 1 : 0;
  endfunction

  task automatic check_outputs(string tag);
    chk("R10", "state", int'(state_o), m_st);
    chk(tag, "acc_ready", int'(acc_ready), (m_st == 0) ? 1 : 0);
    chk(tag, "early_wake", int'(early_wake), (m_st != 2) ? 1 : 0);
    chk(tag, "full_wake", int'(full_wake), exp_full());
  endtask

  task automatic model_step();
    bit acc, tick, iexp, wdone, rst_cnt;
    int nst;
    acc     = (m_st == 0) && acc_valid;
    tick    = decay_en && (decay_period != 0) && (m_dcnt + 1 >= int'(decay_period));
    iexp    = (m_lim != 0) && (m_cnt + 1 >= m_lim);
    wdone   = (m_st == 1) && (m_wcnt == GAP);
    rst_cnt = acc || wdone;
    nst = m_st;
    if (m_st == 0 && !acc && (decay_en ? tick : iexp)) nst = 2;
    if (wdone) nst = 0;
    if (m_st == 2 && acc_valid) nst = 1;
    m_wcnt = (m_st == 1 && !wdone) ? m_wcnt + 1 : 0;
    if (rst_cnt) begin
      m_cnt = 0;
      m_lim = int'(idle_limit);
    end else if (m_st == 0 && m_cnt < 65535) begin
      m_cnt++;
    end
    if (rst_cnt || tick) m_dcnt = 0;
    else                 m_dcnt = (m_dcnt + 1) & 65535;
    m_st = nst;
  endtask

  task automatic step(string tag);
    #1;
    check_outputs(tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    acc_valid = 1'b0;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic access(string tag);
    acc_valid = 1'b1;
    step(tag);
    acc_valid = 1'b0;
  endtask

  // raise valid, hold until ready; returns the number of cycles ready was low
  task automatic wake_access(string tag, output int waited);
    waited = 0;
    acc_valid = 1'b1;
    #1;
    while (!acc_ready && waited < 50) begin
      waited++;
      step(tag);
      #1;
    end
    step(tag);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; acc_valid = 1'b0; idle_limit = '0;
    decay_en = 1'b0; decay_period = '0;
    m_st = 0; m_cnt = 0; m_lim = 0; m_dcnt = 0; m_wcnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1", "reset state", int'(state_o), 0);
    chk("R1", "reset full_wake", int'(full_wake), 1);
    rst_n = 1'b1;

    // R1: threshold programmed but not yet latched -> stays awake
    idle_limit = 16'd3;
    idle(10, "R1");
    chk("R1", "awake before first restart", int'(state_o), 0);

    // R2: access then exactly three idle cycles
    access("R3");
    idle(2, "R2");
    #1 chk("R2", "still active after 2 idle", int'(state_o), 0);
    idle(1, "R2");
    #1 chk("R2", "asleep after 3 idle", int'(state_o), 2);

    // R5: stays asleep, rails off
    idle(5, "R5");

    // R6: wake sequencing
    wake_access("R6", w);
    chk("R6", "ready-low cycles during wake", w, GAP + 2);

    // R3: repeated accesses keep it awake; mid-count change ignored
    idle_limit = 16'd4;
    access("R3");
    for (int k = 0; k < 4; k++) begin
      idle(2, "R3");
      access("R3");
    end
    idle_limit = 16'd2;
    idle(3, "R3");
    #1 chk("R3", "old threshold still in force", int'(state_o), 0);
    idle(1, "R3");
    #1 chk("R3", "asleep at latched threshold", int'(state_o), 2);
    wake_access("R6", w);

    // R4: zero threshold disables idle sleep
    idle_limit = 16'd0;
    access("R4");
    idle(40, "R4");
    #1 chk("R4", "never sleeps with zero threshold", int'(state_o), 0);

    // R8: decay mode ticks regardless of idle threshold
    decay_en = 1'b1; decay_period = 16'd5;
    access("R9");
    idle(4, "R8");
    #1 chk("R8", "active before decay tick", int'(state_o), 0);
    idle(1, "R8");
    #1 chk("R8", "asleep on decay tick", int'(state_o), 2);
    wake_access("R9", w);
    // R9: accesses restart the decay count
    for (int k = 0; k < 5; k++) begin
      idle(3, "R9");
      access("R9");
    end
    #1 chk("R9", "restarted decay keeps awake", int'(state_o), 0);
    // R8: period zero never ticks
    decay_period = 16'd0;
    idle(30, "R8");
    #1 chk("R8", "zero period no tick", int'(state_o), 0);
    decay_period = 16'd3;
    idle(3, "R8");
    #1 chk("R8", "live period change", int'(state_o), 2);
    wake_access("R6", w);

    // R7: constrained random traffic with valid held until accepted
    for (int c = 0; c < 4000; c++) begin
      #1;
      if (!(acc_valid && !acc_ready)) acc_valid = (($urandom % 4) == 0);
      if (($urandom % 16) == 0) idle_limit = 16'($urandom % 7);
      if (($urandom % 200) == 0) decay_en = ~decay_en;
      if (($urandom % 32) == 0) decay_period = 16'($urandom % 8);
      step("R7");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule